// File: doc/BRIEF.md
# Serial Byte Receiver with Mid-Bit Sampling and Overrun Hold

This block receives asynchronous serial bytes, eight data bits with no parity and one stop bit. It runs from a single kernel clock. A 4-bit selector picks a prescaler ratio for that clock. The prescaled ticks then drive a programmable baud counter, so one bit lasts `ratio × baud_div` kernel cycles.

A falling edge on the synchronised line starts a frame. The start bit is confirmed low half a bit later. Each following bit is then captured with exactly one sample at its centre. There is no majority vote and no noise flag.

A finished byte lands in a one-entry holding register and raises a valid flag. Software drops that flag with a read pulse. A byte that completes while the previous one is still unread is discarded, the stored byte is kept, and a sticky overrun flag is raised. The overrun flag is cleared with a write-one pulse.

Top module: `lpu_rx`

## Requirements
- R1: The prescaler selector `presc_sel` sets these kernel-clock ratios: code 0 gives 1, codes 1 to 6 give 2×code, and codes 7 to 11 give 16, 32, 64, 128 and 256. Codes 12 to 15 give 256.
- R2: A bit lasts `ratio × baud_div` kernel cycles, with `baud_div` of at least 2. The start bit is sampled once, `baud_div/2` prescaled ticks after the falling edge. If the line is high at that sample, the frame is abandoned and no byte is stored.
- R3: Each data bit is sampled once, a whole bit period after the previous sample. The eight bits are assembled least-significant first. The byte appears on `rx_byte` and `byte_valid` rises when the stop bit is sampled.
- R4: A low stop-bit sample sets `frame_err` together with the stored byte, and the byte is still delivered. A high stop-bit sample stores the byte with `frame_err` low.
- R5: A one-cycle `rd_pulse` while `byte_valid` is high clears `byte_valid`.
- R6: If the stop bit of a frame is sampled while `byte_valid` is still high, the new byte is discarded. `rx_byte` and `frame_err` keep the older frame, and `overrun` is set.
- R7: If `rd_pulse` falls in the same cycle as a discarded frame completes, `overrun` becomes 1, `byte_valid` becomes 0 and `rx_byte` still holds the older byte.
- R8: `overrun` stays set until an `ovr_clr` pulse. If a clear and a new loss arrive in the same cycle, the flag stays set.
- R9: While `enable` is low, the receiver is held idle: `byte_valid`, `overrun`, `frame_err` and `rx_byte` are 0, and line activity produces no byte.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low holds everything idle |
| presc_sel | input | 4 | Prescaler ratio selector |
| baud_div | input | BDW | Prescaled ticks per bit (at least 2) |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_pulse | input | 1 | Read of the holding register |
| ovr_clr | input | 1 | Write-one-to-clear of the overrun flag |
| rx_byte | output | 8 | Holding register contents |
| byte_valid | output | 1 | Holding register has an unread byte |
| overrun | output | 1 | At least one frame was lost |
| frame_err | output | 1 | Stop bit of the stored frame was low |

## Verification
All 256 byte values are sent at one bit rate. A design that shifts most-significant first, or samples off centre, returns a different byte. All sixteen prescaler codes are then swept with the bench driving bits at the ratio it computes itself; a wrong ratio or a missing saturation above code 11 garbles the received byte. The sharpest corners are a read landing on the exact cycle a frame is lost, which a naive design answers by storing the new byte or by leaving the valid flag set, and an overrun clear colliding with a fresh loss, where a clear-priority design drops the flag. A short low glitch must be rejected at the start-bit check rather than decoded as 0xFF.

// File: rtl/lpu_rx_pkg.sv
package lpu_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // Terminal count (ratio minus one) for each prescaler code.
  function automatic logic [7:0] presc_limit(input logic [3:0] code);
    logic [7:0] lim;
    case (code)
      4'd0:    lim = 8'd0;
      4'd1:    lim = 8'd1;
      4'd2:    lim = 8'd3;
      4'd3:    lim = 8'd5;
      4'd4:    lim = 8'd7;
      4'd5:    lim = 8'd9;
      4'd6:    lim = 8'd11;
      4'd7:    lim = 8'd15;
      4'd8:    lim = 8'd31;
      4'd9:    lim = 8'd63;
      4'd10:   lim = 8'd127;
      default: lim = 8'd255;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/lpu_rx_sync.sv
module lpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/lpu_rx_presc.sv
module lpu_rx_presc
  import lpu_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [3:0] sel,
  output logic       tick
);
  logic [7:0] lim;
  logic [7:0] cnt_q, cnt_d;

  assign lim  = presc_limit(sel);
  assign tick = en & (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart)    cnt_d = '0;
    else if (cnt_q >= lim) cnt_d = '0;
    else                   cnt_d = cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpu_rx_frame.sv
module lpu_rx_frame
  import lpu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BDW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line,
  input  logic              fall,
  input  logic              tick,
  input  logic [BDW-1:0]    baud_div,
  output logic              restart,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              stop_ok
);
  localparam int IDXW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [BDW-1:0]    bcnt_q, bcnt_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic [BDW-1:0]    full_cnt, half_cnt;

  assign full_cnt = (baud_div < BDW'(2)) ? BDW'(2) : baud_div;
  assign half_cnt = full_cnt >> 1;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    restart = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_START;
          bcnt_d  = '0;
          restart = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          if (bcnt_q == half_cnt - BDW'(1)) begin
            bcnt_d  = '0;
            idx_d   = '0;
            state_d = line ? ST_IDLE : ST_DATA;
          end else begin
            bcnt_d = bcnt_q + BDW'(1);
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (bcnt_q == full_cnt - BDW'(1)) begin
            bcnt_d = '0;
            shr_d  = {line, shr_q[DATA_W-1:1]};
            if (idx_q == LAST_IDX) state_d = ST_STOP;
            else                   idx_d   = idx_q + IDXW'(1);
          end else begin
            bcnt_d = bcnt_q + BDW'(1);
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (bcnt_q == full_cnt - BDW'(1)) begin
            bcnt_d  = '0;
            done    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            bcnt_d = bcnt_q + BDW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!en) begin
      state_d = ST_IDLE;
      bcnt_d  = '0;
      idx_d   = '0;
      restart = 1'b0;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
    end
  end

  assign data    = shr_q;
  assign stop_ok = line;
endmodule

// File: rtl/lpu_rx.sv
module lpu_rx
  import lpu_rx_pkg::*;
#(
  parameter int BDW         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_k,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [3:0]     presc_sel,
  input  logic [BDW-1:0] baud_div,
  input  logic           rxd,
  input  logic           rd_pulse,
  input  logic           ovr_clr,
  output logic [7:0]     rx_byte,
  output logic           byte_valid,
  output logic           overrun,
  output logic           frame_err
);
  localparam int DATA_W = 8;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_k or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              line_s, fall_s, tick_s, restart_s;
  logic              frm_done, frm_stop_ok;
  logic [DATA_W-1:0] frm_data;

  lpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_k),
    .rst_n(rst_int_n),
    .din  (rxd),
    .line (line_s),
    .fall (fall_s)
  );

  lpu_rx_presc u_presc (
    .clk    (clk_k),
    .rst_n  (rst_int_n),
    .en     (enable),
    .restart(restart_s),
    .sel    (presc_sel),
    .tick   (tick_s)
  );

  lpu_rx_frame #(.DATA_W(DATA_W), .BDW(BDW)) u_frame (
    .clk     (clk_k),
    .rst_n   (rst_int_n),
    .en      (enable),
    .line    (line_s),
    .fall    (fall_s),
    .tick    (tick_s),
    .baud_div(baud_div),
    .restart (restart_s),
    .done    (frm_done),
    .data    (frm_data),
    .stop_ok (frm_stop_ok)
  );

  // Holding register and flags.
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              vld_q, vld_d, ovr_q, ovr_d, fe_q, fe_d;
  logic              accept, lost;

  assign accept = frm_done & ~vld_q;
  assign lost   = frm_done &  vld_q;

  always_comb begin
    hold_d = hold_q;
    fe_d   = fe_q;
    vld_d  = vld_q;
    ovr_d  = ovr_q;
    if (accept) begin
      hold_d = frm_data;
      fe_d   = ~frm_stop_ok;
      vld_d  = 1'b1;
    end else if (rd_pulse) begin
      vld_d  = 1'b0;
    end
    if (lost)         ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    if (!enable) begin
      hold_d = '0;
      fe_d   = 1'b0;
      vld_d  = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_k or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_q <= '0;
      fe_q   <= 1'b0;
      vld_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      fe_q   <= fe_d;
      vld_q  <= vld_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_byte    = hold_q;
  assign byte_valid = vld_q;
  assign overrun    = ovr_q;
  assign frame_err  = fe_q;
endmodule

// File: rtl/lpu_rx_chk.sv
module lpu_rx_chk (
  input logic       clk_k,
  input logic       rst_n,
  input logic       enable,
  input logic       rd_pulse,
  input logic       ovr_clr,
  input logic       frm_done,
  input logic [7:0] rx_byte,
  input logic       byte_valid,
  input logic       overrun,
  input logic       frame_err
);
  assert_keep_old_byte_R6: assert property (@(posedge clk_k) disable iff (!rst_n)
    (byte_valid && enable) |=> $stable(rx_byte));

  assert_loss_sets_ovr_R6: assert property (@(posedge clk_k) disable iff (!rst_n)
    (frm_done && byte_valid && enable) |=> overrun);

  assert_read_clears_R5: assert property (@(posedge clk_k) disable iff (!rst_n)
    (byte_valid && rd_pulse) |=> !byte_valid);

  assert_ovr_sticky_R8: assert property (@(posedge clk_k) disable iff (!rst_n)
    (overrun && !ovr_clr && enable) |=> overrun);

  assert_off_idle_R9: assert property (@(posedge clk_k) disable iff (!rst_n)
    !enable |=> (!byte_valid && !overrun && !frame_err && rx_byte == 8'd0));

  assert_valid_from_frame_R3: assert property (@(posedge clk_k) disable iff (!rst_n)
    $rose(byte_valid) |-> $past(frm_done));
endmodule

bind lpu_rx lpu_rx_chk chk_i (
  .clk_k     (clk_k),
  .rst_n     (rst_n),
  .enable    (enable),
  .rd_pulse  (rd_pulse),
  .ovr_clr   (ovr_clr),
  .frm_done  (frm_done),
  .rx_byte   (rx_byte),
  .byte_valid(byte_valid),
  .overrun   (overrun),
  .frame_err (frame_err)
);

// File: tb/lpu_rx_tb_top.sv
`timescale 1ns/1ps
module lpu_rx_tb_top;
  localparam int BDW = 12;

  logic           clk_k = 1'b0;
  logic           rst_n;
  logic           enable;
  logic [3:0]     presc_sel;
  logic [BDW-1:0] baud_div;
  logic           rxd;
  logic           rd_pulse;
  logic           ovr_clr;
  logic [7:0]     rx_byte;
  logic           byte_valid, overrun, frame_err;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #2.5 clk_k = ~clk_k;

  lpu_rx #(.BDW(BDW)) dut_i (
    .clk_k(clk_k), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
    .baud_div(baud_div), .rxd(rxd), .rd_pulse(rd_pulse), .ovr_clr(ovr_clr),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .overrun(overrun),
    .frame_err(frame_err)
  );

  function automatic int ratio_of(input int code);
    if (code == 0)  return 1;
    if (code <= 6)  return 2 * code;
    if (code <= 11) return 1 << (code - 3);
    return 256;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One frame: start, 8 data bits LSB first, stop. Optional pulses on the
  // cycle the stop bit is sampled: 2 sync flops + 1 edge flop, half a bit,
  // then nine bit periods.
  task automatic send(input logic [7:0] b, input logic stop_bit,
                      input bit rd_at_done, input bit clr_at_done);
    int r, p, d;
    r = ratio_of(int'(presc_sel));
    p = r * int'(baud_div);
    d = 2 + (int'(baud_div) / 2) * r + 9 * p;
    fork
      begin
        @(negedge clk_k); rxd = 1'b0;
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk_k);
          rxd = b[i];
        end
        repeat (p) @(negedge clk_k); rxd = stop_bit;
        repeat (p) @(negedge clk_k); rxd = 1'b1;
        repeat (3) @(negedge clk_k);
      end
      begin
        if (rd_at_done || clr_at_done) begin
          @(negedge clk_k);
          repeat (d) @(negedge clk_k);
          rd_pulse = rd_at_done;
          ovr_clr  = clr_at_done;
          @(negedge clk_k);
          rd_pulse = 1'b0;
          ovr_clr  = 1'b0;
        end
      end
    join
  endtask

  task automatic pulse_rd();
    rd_pulse = 1'b1; @(negedge clk_k); rd_pulse = 1'b0; @(negedge clk_k);
  endtask

  task automatic pulse_clr();
    ovr_clr = 1'b1; @(negedge clk_k); ovr_clr = 1'b0; @(negedge clk_k);
  endtask

  initial begin
    repeat (190000) @(posedge clk_k);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; presc_sel = 4'd0; baud_div = BDW'(8);
    rxd = 1'b1; rd_pulse = 1'b0; ovr_clr = 1'b0;
    repeat (4) @(negedge clk_k);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_k);
    // R10 reset state
    check("R10 byte_valid", byte_valid, 0);
    check("R10 overrun", overrun, 0);
    check("R10 frame_err", frame_err, 0);
    check("R10 rx_byte", rx_byte, 0);
    enable = 1'b1;
    repeat (4) @(negedge clk_k);

    // R3: every byte value, ratio 1, 4 ticks per bit
    baud_div = BDW'(4);
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1, 0, 0);
      check("R3 data", rx_byte, v);
      check("R3 valid", byte_valid, 1);
      check("R4 clean stop", frame_err, 0);
      pulse_rd();
      check("R5 read clears", byte_valid, 0);
    end

    // R1: every prescaler code, bench paces bits at its own ratio
    for (int c = 0; c < 16; c++) begin
      presc_sel = 4'(c);
      send(8'(8'hA5 ^ (c * 17)), 1'b1, 0, 0);
      check("R1 prescaled byte", rx_byte, int'(8'(8'hA5 ^ (c * 17))));
      check("R1 valid", byte_valid, 1);
      pulse_rd();
    end
    presc_sel = 4'd0;
    baud_div  = BDW'(8);

    // R2: low glitch shorter than half a bit is rejected
    @(negedge clk_k); rxd = 1'b0;
    repeat (2) @(negedge clk_k); rxd = 1'b1;
    repeat (30) @(negedge clk_k);
    check("R2 glitch rejected", byte_valid, 0);
    send(8'h3C, 1'b1, 0, 0);
    check("R2 frame after glitch", rx_byte, 8'h3C);
    pulse_rd();

    // R4: low stop bit flags framing error, byte still delivered
    send(8'h96, 1'b0, 0, 0);
    check("R4 byte kept", rx_byte, 8'h96);
    check("R4 frame_err", frame_err, 1);
    check("R4 valid", byte_valid, 1);
    pulse_rd();

    // R6: second frame lost, older byte kept
    send(8'h11, 1'b1, 0, 0);
    send(8'h22, 1'b0, 0, 0);
    check("R6 old byte kept", rx_byte, 8'h11);
    check("R6 overrun", overrun, 1);
    check("R6 valid held", byte_valid, 1);
    check("R6 frame_err of old frame", frame_err, 0);
    pulse_clr();
    check("R8 clear", overrun, 0);
    pulse_rd();
    check("R5 read after overrun", byte_valid, 0);
    check("R5 byte unchanged", rx_byte, 8'h11);

    // R7: read on the very cycle a lost frame completes
    send(8'h5A, 1'b1, 0, 0);
    send(8'hC3, 1'b1, 1, 0);
    check("R7 overrun", overrun, 1);
    check("R7 valid cleared", byte_valid, 0);
    check("R7 byte is older", rx_byte, 8'h5A);
    pulse_clr();

    // R8: clear collides with a fresh loss, set wins
    send(8'h77, 1'b1, 0, 0);
    send(8'h88, 1'b1, 0, 1);
    check("R8 set beats clear", overrun, 1);
    repeat (20) @(negedge clk_k);
    check("R8 sticky", overrun, 1);
    pulse_clr();
    check("R8 cleared", overrun, 0);

    // R9: disable clears and ignores line
    send(8'h44, 1'b1, 0, 0);
    send(8'h45, 1'b0, 0, 0);
    enable = 1'b0;
    @(negedge clk_k);
    check("R9 valid off", byte_valid, 0);
    check("R9 overrun off", overrun, 0);
    check("R9 byte off", rx_byte, 0);
    send(8'hE7, 1'b0, 0, 0);
    check("R9 no byte while off", byte_valid, 0);
    check("R9 no frame_err while off", frame_err, 0);
    enable = 1'b1;
    repeat (4) @(negedge clk_k);
    send(8'hE7, 1'b1, 0, 0);
    check("R9 works after enable", rx_byte, 8'hE7);
    check("R9 valid after enable", byte_valid, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule